// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Data Store with Register Access

This block gives a CPU a small byte-addressed nonvolatile store that is reached only through three special-function registers: an address register, a data register and a control/status register. Software places an address (and, for a write, a value) in the first two, then sets a single bit in the control register to start the access. A read returns the byte in the data register on the following clock. A write runs a timed cycle that first erases the target byte and then programs the new value. The cycle's length comes from a parameterised cycle counter that stands in for an on-chip write timer.

The request bits in the control register are set by software and cleared only by hardware. A separate enable bit must already be 1 before a write request is honoured. A completion flag, also driven on an output pin, marks the end of each write and stays up until software clears it. A warm reset (external or watchdog) that arrives during a write cuts the cycle short and raises an error flag. The storage array survives both warm reset and power-on reset.

Top module: `nvb_ctrl`

## Requirements
- R1: The store holds 64 bytes. The 8-bit address register selects a byte only when its bits 7:6 are both 0. A read at any other address loads 0x00 into the data register. A write at any other address leaves every stored byte unchanged, but its write cycle runs and sets the done flag as usual.
- R2: bus_sel picks the register: 0 is the address, 1 is the data, 2 is control/status, and 3 reads as 0x00. The control bits are: bit 0 read request, bit 1 write request/busy, bit 2 write enable, bit 3 error flag and bit 4 done flag. Bits 7:5 always read 0.
- R3: Writing the control register with bit 0 set raises the read bit. On the next clock edge the data register takes the addressed byte and the read bit returns to 0.
- R4: A write cycle starts only when the control register is written with bit 1 set while the stored enable bit is already 1 and no write is running. Otherwise the request is ignored: bit 1 stays 0 and the store keeps its contents.
- R5: The write bit reads 1 for exactly WR_CYCLES clock edges after the starting edge and is then cleared by hardware. Writing 0 to bit 0 or bit 1 never clears either bit.
- R6: On the first edge after the start, a write sets its target byte to the erased value 0xFF. The new value is programmed into the byte on the edge that ends the cycle.
- R7: The done flag (bit 4, mirrored on wr_done_irq) goes to 1 on the edge that ends a write. It stays at 1 until software writes 0 to bit 4.
- R8: A warm_rst pulse during a write aborts the write. It sets the error flag and clears the write, read and enable bits. The target byte is left erased. The address register, the data register and the other bytes are kept.
- R9: Power-on reset (rst_n low) clears the address, data and control registers to 0x00 and leaves the stored bytes untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous external/watchdog reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select for writes and reads |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| wr_done_irq | output | 1 | Copy of the done flag |

## Verification
The data register holds a read result on the first edge after the edge that set the read bit. The bench therefore samples it at the next falling edge, after it has first confirmed that the read bit was visible for one cycle. A write's busy bit is checked as still 1 at the falling edge after edge WR_CYCLES-1 and as cleared, with done set, one falling edge later. That pins the cycle length to exactly WR_CYCLES. The erase phase is observed by issuing a read one edge after the start, so the array is sampled just after it has been erased and long before programming. All inputs change and all outputs are sampled on falling edges.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

  localparam int B_RD   = 0;
  localparam int B_WR   = 1;
  localparam int B_EN   = 2;
  localparam int B_ERR  = 3;
  localparam int B_DONE = 4;

  // true when every address bit above the implemented index is zero
  function automatic logic addr_ok(input logic [REG_W-1:0] a, input int idx_w);
    return (a >> idx_w) == '0;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctl(input logic done, input logic err,
                                                input logic en, input logic wr,
                                                input logic rd);
    return {3'b000, done, err, en, wr, rd};
  endfunction
endpackage

// File: rtl/nvb_array.sv
module nvb_array #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              erase_en,
  input  logic              prog_en,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // no reset: contents survive every reset
  always_ff @(posedge clk) begin
    if (prog_en)       mem[widx] <= wdata;
    else if (erase_en) mem[widx] <= '1;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/nvb_wr_seq.sv
module nvb_wr_seq #(
  parameter int WR_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  output logic busy,
  output logic erase_pulse,
  output logic finish_pulse
);
  localparam int CNT_W = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign erase_pulse  = busy && (cnt == '0) && !abort;
  assign finish_pulse = busy && (cnt == LAST) && !abort;
endmodule

// File: rtl/nvb_regs.sv
module nvb_regs
  import nvb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             bus_we,
  input  logic [1:0]       bus_sel,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             wr_busy,
  input  logic             wr_finish,
  input  logic [REG_W-1:0] arr_rdata,
  output logic [REG_W-1:0] addr_q,
  output logic [REG_W-1:0] data_q,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] bus_rdata,
  output logic             wr_start,
  output logic             rd_fire
);
  logic rd_q, en_q, err_q, done_q;
  logic ctl_wr;

  assign ctl_wr   = bus_we && (bus_sel == SEL_CTL);
  assign wr_start = ctl_wr && bus_wdata[B_WR] && en_q && !wr_busy && !abort;
  assign rd_fire  = rd_q && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (bus_we && bus_sel == SEL_ADDR) addr_q <= bus_wdata;

      if (rd_fire)
        data_q <= addr_ok(addr_q, IDX_W) ? arr_rdata : '0;
      else if (bus_we && bus_sel == SEL_DATA)
        data_q <= bus_wdata;

      if (abort) begin
        rd_q <= 1'b0;
        en_q <= 1'b0;
        if (wr_busy)     err_q <= 1'b1;
        else if (ctl_wr) err_q <= bus_wdata[B_ERR];
      end else begin
        // read request: set-only by software, cleared after one cycle
        rd_q <= (ctl_wr && bus_wdata[B_RD]) ? 1'b1 : 1'b0;
        if (ctl_wr) begin
          en_q  <= bus_wdata[B_EN];
          err_q <= bus_wdata[B_ERR];
        end
      end

      if (wr_finish)   done_q <= 1'b1;
      else if (ctl_wr) done_q <= bus_wdata[B_DONE];
    end
  end

  assign ctl_q = pack_ctl(done_q, err_q, en_q, wr_busy, rd_q);

  always_comb begin
    case (bus_sel)
      SEL_ADDR: bus_rdata = addr_q;
      SEL_DATA: bus_rdata = data_q;
      SEL_CTL:  bus_rdata = ctl_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
  import nvb_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int WR_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic             bus_we,
  input  logic [1:0]       bus_sel,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             wr_done_irq
);
  // named internal events, watched by the bound checker
  logic             wr_start, wr_busy, wr_finish, erase_pulse, rd_fire;
  logic [REG_W-1:0] addr_q, data_q, ctl_q, arr_rdata;
  logic [IDX_W-1:0] tgt_idx;
  logic [REG_W-1:0] tgt_dat;
  logic             tgt_ok;

  nvb_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .abort(warm_rst),
    .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .wr_busy(wr_busy), .wr_finish(wr_finish), .arr_rdata(arr_rdata),
    .addr_q(addr_q), .data_q(data_q), .ctl_q(ctl_q), .bus_rdata(bus_rdata),
    .wr_start(wr_start), .rd_fire(rd_fire)
  );

  nvb_wr_seq #(.WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(warm_rst), .start(wr_start),
    .busy(wr_busy), .erase_pulse(erase_pulse), .finish_pulse(wr_finish)
  );

  // target is captured at start so later register writes cannot disturb it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_idx <= '0;
      tgt_dat <= '0;
      tgt_ok  <= 1'b0;
    end else if (wr_start) begin
      tgt_idx <= addr_q[IDX_W-1:0];
      tgt_dat <= data_q;
      tgt_ok  <= addr_ok(addr_q, IDX_W);
    end
  end

  nvb_array #(.IDX_W(IDX_W), .DATA_W(REG_W)) u_array (
    .clk(clk),
    .erase_en(erase_pulse && tgt_ok),
    .prog_en(wr_finish && tgt_ok),
    .widx(tgt_idx), .wdata(tgt_dat),
    .ridx(addr_q[IDX_W-1:0]), .rdata(arr_rdata)
  );

  assign wr_done_irq = ctl_q[B_DONE];
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       warm_rst,
  input logic       rd_set,
  input logic [7:0] ctl,
  input logic       wr_start,
  input logic       wr_finish
);
  AST_CTL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[7:5] == 3'b000); // R2

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0] && !rd_set) |=> !ctl[0]); // R3

  AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (ctl[2] && !ctl[1])); // R4

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[1] && !wr_finish && !warm_rst) |=> ctl[1]); // R5

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_finish |=> (ctl[4] && !ctl[1])); // R7

  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && ctl[1]) |=> (ctl[3] && !ctl[1] && !ctl[2] && !ctl[0])); // R8
endmodule

bind nvb_ctrl nvb_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
  .rd_set(bus_we && bus_sel == 2'd2 && bus_wdata[0]),
  .ctl(ctl_q), .wr_start(wr_start), .wr_finish(wr_finish)
);

// File: tb/sim_nvb_ctrl.sv
`timescale 1ns/1ps
module sim_nvb_ctrl;
  localparam int WR = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       warm_rst = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wr_done_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  nvb_ctrl #(.IDX_W(6), .WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_done_irq(wr_done_irq)
  );

  // {address, value}
  localparam logic [15:0] VEC [6] = '{
    {8'h00, 8'hA5}, {8'h3F, 8'h3C}, {8'h10, 8'h5A},
    {8'h21, 8'h00}, {8'h2A, 8'hFF}, {8'h07, 8'h96}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // called at a falling edge; the register write lands on the next rising edge
  task automatic bus_write(input logic [1:0] sel, input logic [7:0] val);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = val;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] val);
    bus_sel = sel;
    #0.5;
    val = bus_rdata;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    bus_write(2'd0, a);
    bus_write(2'd1, d);
    bus_write(2'd2, 8'h04);
    bus_write(2'd2, 8'h06);
    repeat (WR) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    bus_write(2'd0, a);
    bus_write(2'd2, 8'h05);
    @(negedge clk);
    peek(2'd1, d);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R9 reset state
    peek(2'd2, v); check("R9 ctl after por", v, 8'h00);
    peek(2'd0, v); check("R9 addr after por", v, 8'h00);
    peek(2'd1, v); check("R9 data after por", v, 8'h00);
    check("R7 irq after por", {7'd0, wr_done_irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // table of write/readback vectors
    for (int i = 0; i < 6; i++) begin
      do_write(VEC[i][15:8], VEC[i][7:0]);
      peek(2'd2, v); check("R7 done after write", v, 8'h14);
      check("R7 irq after write", {7'd0, wr_done_irq}, 8'h01);
      bus_write(2'd2, 8'h04);
      bus_write(2'd0, VEC[i][15:8]);
      bus_write(2'd2, 8'h05);
      peek(2'd2, v); check("R3 read bit raised", v, 8'h05);
      @(negedge clk);
      peek(2'd2, v); check("R3 read bit cleared", v, 8'h04);
      peek(2'd1, v); check("R3 R6 readback", v, VEC[i][7:0]);
    end

    // R2 register map details
    bus_write(2'd0, 8'h2A);
    peek(2'd0, v); check("R2 addr readback", v, 8'h2A);
    peek(2'd3, v); check("R2 select 3 reads zero", v, 8'h00);
    bus_write(2'd2, 8'hE4);
    peek(2'd2, v); check("R2 bits 7:5 zero", v, 8'h04);

    // R5 R6 cycle length, set-only bits, erase before program
    bus_write(2'd0, 8'h21);
    bus_write(2'd1, 8'h44);
    bus_write(2'd2, 8'h06);              // start edge E0
    bus_write(2'd2, 8'h05);              // E1: read request with bit1 = 0
    peek(2'd2, v); check("R5 write bit not cleared by software", v & 8'h02, 8'h02);
    @(negedge clk);                      // after E2: read of erased byte
    peek(2'd1, v); check("R6 target erased first", v, 8'hFF);
    peek(2'd2, v); check("R5 read bit not cleared early", v & 8'h01, 8'h00);
    repeat (WR - 3) @(negedge clk);      // after E(WR-1)
    peek(2'd2, v); check("R5 busy through last cycle", v & 8'h12, 8'h02);
    @(negedge clk);                      // after E(WR)
    peek(2'd2, v); check("R5 R7 busy cleared and done", v & 8'h12, 8'h10);
    repeat (4) @(negedge clk);
    check("R7 done sticky", {7'd0, wr_done_irq}, 8'h01);
    bus_write(2'd2, 8'h04);
    check("R7 done cleared by software", {7'd0, wr_done_irq}, 8'h00);
    do_read(8'h21, v); check("R6 programmed value", v, 8'h44);

    // R4 write without enable
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'h07);
    bus_write(2'd1, 8'h22);
    bus_write(2'd2, 8'h02);
    peek(2'd2, v); check("R4 request ignored without enable", v, 8'h00);
    repeat (WR + 2) @(negedge clk);
    check("R4 no done without enable", {7'd0, wr_done_irq}, 8'h00);
    do_read(8'h07, v); check("R4 array unchanged", v, 8'h96);

    // R1 out-of-range accesses
    do_write(8'h40, 8'h11);
    peek(2'd2, v); check("R1 out-of-range write still done", v & 8'h10, 8'h10);
    bus_write(2'd2, 8'h04);
    do_read(8'h40, v); check("R1 out-of-range read is zero", v, 8'h00);
    do_read(8'h00, v); check("R1 alias byte unchanged", v, 8'hA5);

    // R8 warm reset during a write
    bus_write(2'd0, 8'h10);
    bus_write(2'd1, 8'h33);
    bus_write(2'd2, 8'h04);
    bus_write(2'd2, 8'h06);
    repeat (3) @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    peek(2'd2, v); check("R8 error set, bits cleared", v, 8'h08);
    peek(2'd1, v); check("R8 data register kept", v, 8'h33);
    repeat (WR) @(negedge clk);
    check("R8 no done after abort", {7'd0, wr_done_irq}, 8'h00);
    do_read(8'h10, v); check("R8 target left erased", v, 8'hFF);
    do_read(8'h3F, v); check("R8 other byte kept", v, 8'h3C);
    bus_write(2'd2, 8'h00);
    peek(2'd2, v); check("R8 error cleared by software", v, 8'h00);

    // R9 power-on reset keeps the array
    bus_write(2'd0, 8'h2A);
    bus_write(2'd2, 8'h14);
    rst_n = 1'b0;
    @(negedge clk);
    peek(2'd2, v); check("R9 ctl cleared", v, 8'h00);
    peek(2'd0, v); check("R9 addr cleared", v, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(8'h2A, v); check("R9 array preserved", v, 8'hFF);
    do_read(8'h3F, v); check("R9 array preserved 3F", v, 8'h3C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule